// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port sitting on a plain memory-mapped register bus (address, write data, write strobe, read strobe, read data). Each pin has its own direction bit, held in a direction register at byte offset 0x400. A pin set as an output drives its output-data bit onto `pin_out_o` and raises its bit of `pin_oe_o`. A pin set as an input is sampled from `pin_i` through a two-flop synchronizer before any read can see it.

The data register is not reached through a single address. It is mirrored across the 256 word addresses from 0x000 to 0x3FC, and address bits [9:2] act as a per-pin select for that access. A write changes only the selected output bits, so software can set or clear any group of pins in one bus cycle without first reading the register. A read returns the selected pins and zero in every other bit position. Registers are one byte wide; only the low eight bits of the data bus carry information.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, `pin_oe_o` is 0x00, `pin_out_o` is 0x00 and `rdata_o` is 0. Reads of the direction register and of the data register both return 0 while `pin_i` is low.
- R2: A write to byte address 0x400 loads `wdata_i[7:0]` into the direction register. `pin_oe_o` then equals that value, where bit n = 1 makes pin n an output and 0 makes it an input. A read of 0x400 returns the stored value.
- R3: A write to any address from 0x000 to 0x3FC updates output-data bit n from `wdata_i[n]` only when address bit n+2 is 1. Every other output-data bit keeps its value, so a write to address 0x000 changes nothing.
- R4: A read of any address from 0x000 to 0x3FC returns the pin value in bit n when address bit n+2 is 1, and returns 0 in every other bit.
- R5: For the pin value used by R4, a pin whose direction bit is 1 reports its output-data bit, and a pin whose direction bit is 0 reports its synchronized input level.
- R6: A change on `pin_i` reaches a data read only after two synchronizer stages. A read whose strobe is sampled at the second rising edge after the change still returns the old level. A read sampled at the third edge returns the new level.
- R7: Writes to any address that is neither in 0x000–0x3FC nor equal to 0x400 leave `pin_oe_o` and `pin_out_o` unchanged. Reads of such addresses return 0.
- R8: `wdata_i[31:8]` is ignored, and `rdata_o[31:8]` is always 0.
- R9: Write effects appear on `pin_oe_o` and `pin_out_o` right after the rising edge that samples `we_i`, and not before it. Read data is registered: it appears on `rdata_o` after the edge that samples `re_i`, and `rdata_o` is 0 in any cycle that follows an edge where `re_i` was low.
- R10: The output-data register keeps and drives its bits on `pin_out_o` whatever the direction bits are. Writing the data register while a pin is an input still updates that pin's output bit, and changing direction never alters the output-data register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Byte address of the access |
| wdata_i | input | 32 | Write data; only bits [7:0] are used |
| we_i | input | 1 | Write strobe, sampled at the rising edge |
| re_i | input | 1 | Read strobe, sampled at the rising edge |
| rdata_o | output | 32 | Registered read data |
| pin_i | input | 8 | External pin levels, asynchronous |
| pin_oe_o | output | 8 | Per-pin output enable (direction register) |
| pin_out_o | output | 8 | Per-pin output value (output-data register) |

## Verification
Register writes are due on `pin_oe_o` and `pin_out_o` one edge after the strobe, and read data is due on `rdata_o` one edge after the read strobe. The bench therefore drives every request on a falling edge and samples the result on the next falling edge. A pin change takes three edges to reach read data: two for the synchronizer and one for the read register. The bench times reads at the second and third edge after a pin change to catch both the stale and the fresh value. For the timing check, the outputs are also sampled once with a write strobe already driven but before its edge, to show that nothing moves early.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  // kind of register a bus address selects
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2
  } acc_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_mask_pkg::*;
#(
  parameter int unsigned            NUM_PINS   = 8,
  parameter int unsigned            ADDR_W     = 12,
  parameter logic [ADDR_W-1:0]      DIR_OFFSET = 12'h400
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output acc_e                acc_o,
  output logic [NUM_PINS-1:0] mask_o
);

  localparam int unsigned MASK_LO = 2;
  localparam int unsigned MASK_HI = NUM_PINS + MASK_LO;

  logic unused_lsb;
  assign unused_lsb = ^addr_i[MASK_LO-1:0];

  // mask field lives in the word-address bits
  assign mask_o = addr_i[MASK_HI-1:MASK_LO];

  always_comb begin
    acc_o = ACC_NONE;
    if (addr_i[ADDR_W-1:MASK_HI] == '0) begin
      acc_o = ACC_DATA;
    end else if (addr_i[ADDR_W-1:MASK_LO] == DIR_OFFSET[ADDR_W-1:MASK_LO]) begin
      acc_o = ACC_DIR;
    end
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_mask_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  acc_e                acc_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] out_o
);

  logic dir_wr, data_wr;
  assign dir_wr  = we_i && (acc_i == ACC_DIR);
  assign data_wr = we_i && (acc_i == ACC_DATA);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dir_o[i] <= 1'b0;
        out_o[i] <= 1'b0;
      end else begin
        if (dir_wr)                dir_o[i] <= wdata_i[i];
        if (data_wr && mask_i[i])  out_o[i] <= wdata_i[i];
      end
    end
  end

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned       NUM_PINS    = 8,
  parameter int unsigned       ADDR_W      = 12,
  parameter int unsigned       DATA_W      = 32,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DIR_OFFSET  = 12'h400
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                we_i,
  input  logic                re_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_out_o
);

  localparam int unsigned PAD_W = DATA_W - NUM_PINS;

  acc_e                acc;
  logic [NUM_PINS-1:0] mask;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] dir_q, out_q;
  logic [NUM_PINS-1:0] pin_view, rd_pins;
  logic [DATA_W-1:0]   rdata_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_PINS];

  gpio_addr_dec #(
    .NUM_PINS   (NUM_PINS),
    .ADDR_W     (ADDR_W),
    .DIR_OFFSET (DIR_OFFSET)
  ) u_dec (
    .addr_i (addr_i),
    .acc_o  (acc),
    .mask_o (mask)
  );

  gpio_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  gpio_port_regs #(
    .NUM_PINS (NUM_PINS)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .acc_i   (acc),
    .mask_i  (mask),
    .wdata_i (wdata_i[NUM_PINS-1:0]),
    .dir_o   (dir_q),
    .out_o   (out_q)
  );

  // outputs report what they drive, inputs what was sampled
  assign pin_view = (dir_q & out_q) | (~dir_q & pin_sync);

  always_comb begin
    unique case (acc)
      ACC_DATA: rd_pins = pin_view & mask;
      ACC_DIR:  rd_pins = dir_q;
      default:  rd_pins = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= {{PAD_W{1'b0}}, rd_pins};
    else           rdata_q <= '0;
  end

  assign rdata_o   = rdata_q;
  assign pin_oe_o  = dir_q;
  assign pin_out_o = out_q;

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int unsigned       NUM_PINS   = 8,
  parameter int unsigned       ADDR_W     = 12,
  parameter int unsigned       DATA_W     = 32,
  parameter logic [ADDR_W-1:0] DIR_OFFSET = 12'h400
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic                we_i,
  input logic                re_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic [NUM_PINS-1:0] pin_out_o
);

  localparam int unsigned MHI = NUM_PINS + 2;

  logic                is_data, is_dir;
  logic [NUM_PINS-1:0] sel;
  logic [NUM_PINS-1:0] wbyte;

  assign is_data = addr_i[ADDR_W-1:MHI] == '0;
  assign is_dir  = addr_i[ADDR_W-1:2] == DIR_OFFSET[ADDR_W-1:2];
  assign sel     = addr_i[MHI-1:2];
  assign wbyte   = wdata_i[NUM_PINS-1:0];

  logic unused_chk;
  assign unused_chk = ^{addr_i[1:0], wdata_i[DATA_W-1:NUM_PINS]};

  // R2
  dir_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && is_dir) |=> pin_oe_o == $past(wbyte));

  // R3
  masked_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && is_data) |=> ((pin_out_o ^ $past(wbyte)) & $past(sel)) == '0);

  // R3
  masked_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && is_data) |=> ((pin_out_o ^ $past(pin_out_o)) & ~$past(sel)) == '0);

  // R4
  read_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && is_data) |=> (rdata_o[NUM_PINS-1:0] & ~$past(sel)) == '0);

  // R7
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !is_data && !is_dir) |=> $stable(pin_oe_o) && $stable(pin_out_o));

  // R7
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !is_data && !is_dir) |=> rdata_o == '0);

  // R8
  rdata_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:NUM_PINS] == '0);

  // R9
  idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> rdata_o == '0);

  // R10
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(pin_oe_o) && $stable(pin_out_o));

  // R10
  dir_wr_keeps_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && is_dir) |=> $stable(pin_out_o));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
  .NUM_PINS   (NUM_PINS),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .DIR_OFFSET (DIR_OFFSET)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .we_i      (we_i),
  .re_i      (re_i),
  .rdata_o   (rdata_o),
  .pin_oe_o  (pin_oe_o),
  .pin_out_o (pin_out_o)
);

// File: tb/gpio_mask_port_test.sv
`timescale 1ns/1ps
module gpio_mask_port_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [31:0] rdata_o;
  logic [7:0]  pin_i = '0;
  logic [7:0]  pin_oe_o;
  logic [7:0]  pin_out_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_mask_port uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .we_i      (we_i),
    .re_i      (re_i),
    .rdata_o   (rdata_o),
    .pin_i     (pin_i),
    .pin_oe_o  (pin_oe_o),
    .pin_out_o (pin_out_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // drive on a falling edge, effect visible at the next falling edge
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    addr_i = a; re_i = 1'b1;
    @(negedge clk_i);
    re_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 oe", {24'h0, pin_oe_o}, 32'h0);
    check("R1 out", {24'h0, pin_out_o}, 32'h0);
    check("R1 rdata", rdata_o, 32'h0);
    bus_read(12'h400, d); check("R1 dir read", d, 32'h0);
    bus_read(12'h3FC, d); check("R1 data read", d, 32'h0);
  endtask

  task automatic t_dir();
    logic [31:0] d;
    bus_write(12'h400, 32'hFFFF_FF5A);
    check("R2 oe", {24'h0, pin_oe_o}, 32'h5A);
    bus_read(12'h400, d);
    check("R2 R8 dir readback", d, 32'h0000_005A);
  endtask

  task automatic t_masked_write();
    bus_write(12'h400, 32'hFF);
    bus_write(12'h3FC, 32'h00);
    check("R3 full clear", {24'h0, pin_out_o}, 32'h00);
    bus_write(12'h03C, 32'hFF);
    check("R3 low nibble", {24'h0, pin_out_o}, 32'h0F);
    bus_write(12'h280, 32'h20);
    check("R3 bits 7,5", {24'h0, pin_out_o}, 32'h2F);
    bus_write(12'h000, 32'hFF);
    check("R3 empty mask", {24'h0, pin_out_o}, 32'h2F);
  endtask

  task automatic t_masked_read();
    logic [31:0] d;
    bus_read(12'h3C0, d); check("R4 upper mask", d, 32'h20);
    bus_read(12'h03C, d); check("R4 lower mask", d, 32'h0F);
    bus_read(12'h204, d); check("R4 bits 7,0", d, 32'h01);
  endtask

  task automatic t_mixed();
    logic [31:0] d;
    bus_write(12'h400, 32'h0F);
    check("R10 dir keeps out", {24'h0, pin_out_o}, 32'h2F);
    pin_i = 8'hC3;
    repeat (3) @(negedge clk_i);
    bus_read(12'h3FC, d); check("R5 mixed view", d, 32'hCF);
    bus_write(12'h3FC, 32'h55);
    check("R10 input pin out bits", {24'h0, pin_out_o}, 32'h55);
    bus_read(12'h3FC, d); check("R5 R10 mixed after write", d, 32'hC5);
  endtask

  task automatic t_sync();
    logic [31:0] d;
    bus_write(12'h400, 32'h00);
    pin_i = 8'h00;
    repeat (3) @(negedge clk_i);
    pin_i = 8'hA5;
    @(negedge clk_i);
    bus_read(12'h3FC, d); check("R6 second edge stale", d, 32'h00);
    bus_read(12'h3FC, d); check("R6 third edge fresh", d, 32'hA5);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_write(12'h400, 32'h3C);
    bus_write(12'h3FC, 32'h99);
    bus_write(12'h404, 32'hFF);
    bus_write(12'h800, 32'hFF);
    bus_write(12'hFFC, 32'h00);
    check("R7 oe held", {24'h0, pin_oe_o}, 32'h3C);
    check("R7 out held", {24'h0, pin_out_o}, 32'h99);
    bus_read(12'h404, d); check("R7 read 0x404", d, 32'h0);
    bus_read(12'hFFC, d); check("R7 read 0xFFC", d, 32'h0);
  endtask

  task automatic t_timing();
    logic [31:0] d;
    bus_read(12'h400, d);
    check("R9 read due", d, 32'h3C);
    @(negedge clk_i);
    check("R9 idle rdata", rdata_o, 32'h0);
    addr_i = 12'h400; wdata_i = 32'hC3; we_i = 1'b1;
    #1;
    check("R9 no early write", {24'h0, pin_oe_o}, 32'h3C);
    @(negedge clk_i);
    we_i = 1'b0;
    check("R9 write after edge", {24'h0, pin_oe_o}, 32'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_dir();
    t_masked_write();
    t_masked_read();
    t_mixed();
    t_sync();
    t_unmapped();
    t_timing();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule